// File: doc/BRIEF.md
# Floating-Point NaN Result Selector

This unit sits beside a single-precision add, subtract, multiply and fused multiply-accumulate datapath. On each accepted operation it decides whether the arithmetic result must be replaced by a NaN, which NaN that is, and whether the invalid-operation flag is raised. When no NaN operand and no invalid case is present it leaves the override bit low, so the main datapath result is used. Rounding, overflow, underflow and inexact handling belong to the datapath and are not part of this block.

Two NaN policies are selectable per operation through `in_compat`. The standard policy (`in_compat` = 0) quiets any returned signaling NaN and flags it. The compatible policy (`in_compat` = 1) returns the chosen NaN bit-for-bit and never flags NaN propagation. The two policies also use different operand priority orders. Operation codes: 0 add, 1 sub, 2 mul, 3 madd, 4 msub, 5 to 7 reserved. For two-operand codes `in_src0` is the first and `in_src1` the second operand; for three-operand codes `in_src0` is the accumulator, `in_src1` the first multiplicand and `in_src2` the second multiplicand.

Top module: `fp_nan_select`

## Requirements
- R1: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are nonzero; it is quiet when bit 22 is set. Quieting sets bit 22 and keeps the sign and all other bits. The default NaN is 0x7fc00000. Whenever the override bit is high the result is a NaN, and under the standard policy it is quiet.
- R2: Outputs change one clock after `in_valid`; `res_valid` is high exactly in that cycle. While `res_valid` is low, and after reset, override, invalid and value are all zero.
- R3: With no NaN operand and no invalid case, or with a reserved opcode, the result has override 0, invalid 0 and value 0.
- R4: Standard policy, two-operand op, exactly one NaN input: that NaN is returned quieted; invalid is raised only if it was signaling.
- R5: Standard policy, two-operand op, both inputs NaN: the second operand is returned quieted; invalid is raised if either is signaling.
- R6: Compatible policy, two-operand op with any NaN input: the first NaN in the order first, second operand is returned unchanged and invalid stays low.
- R7: With no NaN input, add of two infinities of opposite sign, sub of two infinities of equal sign, and mul of infinity by zero (either order) return the default NaN with invalid raised, under both policies.
- R8: Standard policy, three-operand op: NaN priority is accumulator, then second multiplicand, then first multiplicand; the pick is quieted; invalid is raised if any NaN input is signaling.
- R9: Compatible policy, three-operand op: NaN priority is first multiplicand, then second multiplicand, then accumulator; the pick is returned unchanged and invalid never rises.
- R10: Three-operand op whose product is infinity times zero with a NaN accumulator returns the accumulator: quieted with invalid always raised under the standard policy, unchanged with no flag under the compatible policy.
- R11: Three-operand op whose product is infinity times zero with no NaN operand returns the default NaN; invalid is raised under the standard policy only.
- R12: `in_src2` has no effect on two-operand ops; madd and msub give identical results, and sub and msub never alter the sign of a returned NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code (0 add, 1 sub, 2 mul, 3 madd, 4 msub) |
| in_compat | input | 1 | NaN policy: 0 standard, 1 compatible |
| in_src0 | input | 32 | First operand or accumulator |
| in_src1 | input | 32 | Second operand or first multiplicand |
| in_src2 | input | 32 | Second multiplicand (three-operand ops only) |
| res_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| res_override | output | 1 | High when `res_value` must replace the datapath result |
| res_value | output | 32 | Selected NaN |
| res_invalid | output | 1 | Invalid-operation flag |

## Verification
The two functions that meet in one operation are NaN propagation and detection of the infinity-times-zero invalid product, which collide when a three-operand op carries an infinite and a zero multiplicand together with a NaN accumulator. The sweep drives every triple from a ten-value set holding signed zeros, signed infinities, ordinary numbers and quiet and signaling NaNs of both signs, through every opcode under both policies, so that collision arises in many sign and NaN-kind combinations. Each result is judged against an arithmetic decision list in the bench that ranks the invalid product ahead of the NaN priority order for each policy.

// File: rtl/fpns_pkg.sv
package fpns_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_MADD = 3'd3,
        OP_MSUB = 3'd4
    } opcode_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
    } opnd_class_t;

endpackage

// File: rtl/fpns_classify.sv
module fpns_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0]  val,
    output fpns_pkg::opnd_class_t cls
);
    logic exp_ones;
    logic exp_zero;
    logic man_zero;

    always_comb begin
        exp_ones    = &val[EXP_W+MAN_W-1:MAN_W];
        exp_zero    = ~|val[EXP_W+MAN_W-1:MAN_W];
        man_zero    = ~|val[MAN_W-1:0];
        cls.is_nan  = exp_ones && !man_zero;
        cls.is_snan = exp_ones && !man_zero && !val[MAN_W-1];
        cls.is_inf  = exp_ones && man_zero;
        cls.is_zero = exp_zero && man_zero;
    end
endmodule

// File: rtl/fpns_select.sv
module fpns_select #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                     compat,
    input  fpns_pkg::opcode_e        op,
    input  logic [EXP_W+MAN_W:0]     src0,
    input  logic [EXP_W+MAN_W:0]     src1,
    input  logic [EXP_W+MAN_W:0]     src2,
    input  fpns_pkg::opnd_class_t    c0,
    input  fpns_pkg::opnd_class_t    c1,
    input  fpns_pkg::opnd_class_t    c2,
    output logic                     sel_override,
    output logic [EXP_W+MAN_W:0]     sel_value,
    output logic                     sel_invalid
);
    import fpns_pkg::*;

    localparam int W    = EXP_W + MAN_W + 1;
    localparam int SGN  = W - 1;
    localparam logic [W-1:0] QBIT = W'(1) << (MAN_W - 1);
    localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic         any_nan;
    logic         any_snan;
    logic         bad_arith;
    logic         prod_bad;
    logic [W-1:0] pick;

    always_comb begin
        sel_override = 1'b0;
        sel_value    = '0;
        sel_invalid  = 1'b0;
        any_nan      = 1'b0;
        any_snan     = 1'b0;
        bad_arith    = 1'b0;
        prod_bad     = (c1.is_inf && c2.is_zero) || (c1.is_zero && c2.is_inf);
        pick         = '0;
        unique case (op)
            OP_ADD, OP_SUB, OP_MUL: begin
                any_nan  = c0.is_nan || c1.is_nan;
                any_snan = c0.is_snan || c1.is_snan;
                if (op == OP_ADD)
                    bad_arith = c0.is_inf && c1.is_inf && (src0[SGN] != src1[SGN]);
                else if (op == OP_SUB)
                    bad_arith = c0.is_inf && c1.is_inf && (src0[SGN] == src1[SGN]);
                else
                    bad_arith = (c0.is_inf && c1.is_zero) || (c0.is_zero && c1.is_inf);
                if (compat)
                    pick = c0.is_nan ? src0 : src1;
                else
                    pick = c1.is_nan ? src1 : src0;
                sel_override = any_nan || bad_arith;
                sel_invalid  = bad_arith || (!compat && any_snan);
            end
            OP_MADD, OP_MSUB: begin
                any_nan  = c0.is_nan || c1.is_nan || c2.is_nan;
                any_snan = c0.is_snan || c1.is_snan || c2.is_snan;
                if (compat) begin
                    if (prod_bad && c0.is_nan) pick = src0;
                    else if (c1.is_nan)        pick = src1;
                    else if (c2.is_nan)        pick = src2;
                    else                       pick = src0;
                end else begin
                    if (c0.is_nan)             pick = src0;
                    else if (c2.is_nan)        pick = src2;
                    else                       pick = src1;
                end
                sel_override = any_nan || prod_bad;
                sel_invalid  = !compat && (any_snan || prod_bad);
            end
            default: begin
                sel_override = 1'b0;
            end
        endcase
        if (sel_override)
            sel_value = any_nan ? (compat ? pick : (pick | QBIT)) : DNAN;
    end
endmodule

// File: rtl/fp_nan_select.sv
module fp_nan_select #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int SRC_N = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [2:0]             in_op,
    input  logic                   in_compat,
    input  logic [EXP_W+MAN_W:0]   in_src0,
    input  logic [EXP_W+MAN_W:0]   in_src1,
    input  logic [EXP_W+MAN_W:0]   in_src2,
    output logic                   res_valid,
    output logic                   res_override,
    output logic [EXP_W+MAN_W:0]   res_value,
    output logic                   res_invalid
);
    import fpns_pkg::*;

    localparam int W = EXP_W + MAN_W + 1;

    opcode_e      opc;
    logic [W-1:0] srcs [SRC_N];
    opnd_class_t  cls  [SRC_N];
    logic         sel_override;
    logic [W-1:0] sel_value;
    logic         sel_invalid;

    assign opc     = opcode_e'(in_op);
    assign srcs[0] = in_src0;
    assign srcs[1] = in_src1;
    assign srcs[2] = in_src2;

    for (genvar gi = 0; gi < SRC_N; gi++) begin : g_cls
        fpns_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val (srcs[gi]),
            .cls (cls[gi])
        );
    end

    fpns_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
        .compat       (in_compat),
        .op           (opc),
        .src0         (in_src0),
        .src1         (in_src1),
        .src2         (in_src2),
        .c0           (cls[0]),
        .c1           (cls[1]),
        .c2           (cls[2]),
        .sel_override (sel_override),
        .sel_value    (sel_value),
        .sel_invalid  (sel_invalid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_override <= 1'b0;
            res_value    <= '0;
            res_invalid  <= 1'b0;
        end else begin
            res_valid    <= in_valid;
            res_override <= in_valid && sel_override;
            res_value    <= in_valid ? sel_value : '0;
            res_invalid  <= in_valid && sel_invalid;
        end
    end

    // R2: result strobe follows the input strobe by one clock
    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    p_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    // R2: outputs cleared outside the result cycle
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_override && !res_invalid && res_value == '0));
    // R1: an override always carries a NaN encoding
    p_override_is_nan_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_override |-> (&res_value[W-2:MAN_W] && |res_value[MAN_W-1:0]));
    // R1: standard policy never returns a signaling NaN
    p_std_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_compat && sel_override) |=> res_value[MAN_W-1]);
    // R9: compatible policy never flags a three-operand op
    p_compat_three_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_compat && (opc == OP_MADD || opc == OP_MSUB)) |=> !res_invalid);
    // R7: a raised flag comes with a replacement value
    p_flag_has_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_invalid |-> res_override);
endmodule

// File: tb/tb_fp_nan_select.sv
module tb_fp_nan_select;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'd0;
    logic        in_compat = 1'b0;
    logic [31:0] in_src0 = 32'd0;
    logic [31:0] in_src1 = 32'd0;
    logic [31:0] in_src2 = 32'd0;
    logic        res_valid;
    logic        res_override;
    logic [31:0] res_value;
    logic        res_invalid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fp_nan_select dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_compat(in_compat), .in_src0(in_src0), .in_src1(in_src1),
        .in_src2(in_src2), .res_valid(res_valid), .res_override(res_override),
        .res_value(res_value), .res_invalid(res_invalid)
    );

    function automatic logic [31:0] sample_val(input int k);
        case (k)
            0: return 32'h3f800000;  // +1.0
            1: return 32'h80000000;  // -0
            2: return 32'h00000000;  // +0
            3: return 32'h7f800000;  // +inf
            4: return 32'hff800000;  // -inf
            5: return 32'h7fc00001;  // quiet NaN
            6: return 32'h7f800001;  // signaling NaN
            7: return 32'hffbfffff;  // negative signaling NaN
            8: return 32'hffc00abc;  // negative quiet NaN
            default: return 32'h7f7fffff;
        endcase
    endfunction

    function automatic bit f_nan(input logic [31:0] x);
        return (x[30:23] == 8'hff) && (x[22:0] != 23'd0);
    endfunction
    function automatic bit f_sig(input logic [31:0] x);
        return f_nan(x) && !x[22];
    endfunction
    function automatic bit f_inf(input logic [31:0] x);
        return (x[30:0] == 31'h7f800000);
    endfunction
    function automatic bit f_zero(input logic [31:0] x);
        return (x[30:0] == 31'd0);
    endfunction

    task automatic model(input bit cm, input int op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c,
                         output bit ov, output logic [31:0] v, output bit inv,
                         output string tag);
        bit bad;
        ov = 0; v = 32'd0; inv = 0; tag = "R3";
        if (op <= 2) begin
            if (op == 0)      bad = f_inf(a) && f_inf(b) && (a[31] ^ b[31]);
            else if (op == 1) bad = f_inf(a) && f_inf(b) && !(a[31] ^ b[31]);
            else              bad = (f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b));
            if (f_nan(a) || f_nan(b)) begin
                ov = 1;
                if (cm) begin
                    v = f_nan(a) ? a : b; tag = "R6";
                end else if (f_nan(a) && f_nan(b)) begin
                    v = b | 32'h00400000; inv = f_sig(a) || f_sig(b); tag = "R5";
                end else begin
                    v = (f_nan(a) ? a : b) | 32'h00400000;
                    inv = f_sig(a) || f_sig(b); tag = "R4";
                end
            end else if (bad) begin
                ov = 1; v = 32'h7fc00000; inv = 1; tag = "R7";
            end
        end else if (op <= 4) begin
            bad = (f_inf(b) && f_zero(c)) || (f_zero(b) && f_inf(c));
            if (bad && f_nan(a)) begin
                ov = 1; tag = "R10";
                v = cm ? a : (a | 32'h00400000);
                inv = !cm;
            end else if (f_nan(a) || f_nan(b) || f_nan(c)) begin
                ov = 1;
                if (cm) begin
                    v = f_nan(b) ? b : (f_nan(c) ? c : a); tag = "R9";
                end else begin
                    v = (f_nan(a) ? a : (f_nan(c) ? c : b)) | 32'h00400000;
                    inv = f_sig(a) || f_sig(b) || f_sig(c); tag = "R8";
                end
            end else if (bad) begin
                ov = 1; v = 32'h7fc00000; inv = !cm; tag = "R11";
            end
        end
    endtask

    task automatic check(input string tag, input bit vld, input bit ov,
                         input logic [31:0] v, input bit inv);
        checks++;
        if (res_valid !== vld || res_override !== ov || res_value !== v ||
            res_invalid !== inv) begin
            fails++;
            $display("FAIL %s: got vld=%0b ovr=%0b val=%08h inv=%0b, expected vld=%0b ovr=%0b val=%08h inv=%0b",
                     tag, res_valid, res_override, res_value, res_invalid, vld, ov, v, inv);
        end
    endtask

    initial begin
        bit ov, inv;
        logic [31:0] v;
        string tag;
        repeat (3) @(negedge clk);
        check("R2 reset", 1'b0, 1'b0, 32'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", 1'b0, 1'b0, 32'd0, 1'b0);
        for (int cm = 0; cm < 2; cm++) begin
            for (int op = 0; op < 8; op++) begin
                for (int i = 0; i < 10; i++) begin
                    for (int j = 0; j < 10; j++) begin
                        for (int k = 0; k < 10; k++) begin
                            if (op > 4 && (i + j + k) % 7 != 0) continue;
                            in_compat = cm[0];
                            in_op     = op[2:0];
                            in_src0   = sample_val(i);
                            in_src1   = sample_val(j);
                            in_src2   = sample_val(k);
                            in_valid  = 1'b1;
                            model(cm[0], op, in_src0, in_src1, in_src2, ov, v, inv, tag);
                            if (op < 3 && tag != "R3") tag = {tag, " R12"};
                            if (op == 4) tag = {tag, " R12 msub"};
                            if (ov && !cm[0]) tag = {tag, " R1"};
                            @(negedge clk);
                            in_valid = 1'b0;
                            check(tag, 1'b1, ov, v, inv);
                            @(negedge clk);
                            check("R2 cleared", 1'b0, 1'b0, 32'd0, 1'b0);
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end
endmodule